// File: doc/BRIEF.md
# Phase-Switched Blanking Sample Accumulator

This block integrates the output of a free-running converter that delivers one unsigned detector sample per strobe with no gaps between conversions. A phase-switch input marks which of two receiver states is active. Settling transients are removed by throwing away samples that have already been converted. The stream itself is never held up. After every change of the phase input, a programmable number of samples is dropped.

Every sample that survives blanking is added to the sum that belongs to the current phase. A count of accepted samples is kept for each phase as well. The integration period is a programmable number of strobes. When a period ends, both sums and both counts are presented together with a one-cycle valid pulse. The internal sums restart on the same edge, so the next strobe already belongs to the next period.

Typical settings are a 10 MHz strobe, 10 dropped samples (1 µs) after each switch, phase states of 100 µs, and a period of 10,000 samples (1 ms).

Top module: `phase_blank_accum`

## Requirements
- R1: While `rst` is high at a clock edge, the result outputs become zero and `res_valid` becomes low. After reset the block is blanking, so the first `blank_len` strobed samples are discarded.
- R2: A strobe on which `phase` differs from its value at the previous strobe (or at reset) is a toggle. That sample and the next `blank_len`-1 strobed samples are discarded. With `blank_len` = 0 nothing is discarded.
- R3: A toggle that arrives while blanking is still active restarts the discard count from the full `blank_len`.
- R4: A strobed sample that is not discarded is added to `sum0` and counted in `cnt0` when `phase` is 0. It goes to `sum1` and `cnt1` when `phase` is 1.
- R5: Cycles with `stb` low change neither the accumulation, the blanking, nor the period position.
- R6: The strobe that is the `period_len`-th of a period ends that period. The result outputs include that strobe's sample, and `res_valid` is high for exactly the following cycle. A `period_len` of 0 acts as 1.
- R7: The sums and counts clear on the edge that ends a period. The next accepted sample is the first one of the new period, so no sample is lost or counted twice.
- R8: Full-scale input (4095) over a period of 10,000 samples produces the exact sum 40,950,000, without wrap.
- R9: Between result pulses, `sum0`, `sum1`, `cnt0` and `cnt1` hold their last latched values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stb | input | 1 | A new sample is present this cycle |
| smp | input | SMP_W (12) | Unsigned sample value |
| phase | input | 1 | Phase-switch state (0 or 1) |
| blank_len | input | BLK_W (8) | Samples dropped after each toggle and after reset |
| period_len | input | PER_W (14) | Strobes per integration period |
| res_valid | output | 1 | One-cycle pulse: results updated |
| sum0 | output | ACC_W (28) | Sum of accepted samples in phase 0 |
| sum1 | output | ACC_W (28) | Sum of accepted samples in phase 1 |
| cnt0 | output | PER_W (14) | Accepted samples in phase 0 |
| cnt1 | output | PER_W (14) | Accepted samples in phase 1 |

## Verification
Two functions can fall on the same strobe.

The first pair is the end of a period and a phase toggle. The bench toggles `phase` exactly on the last strobe of a period. It then checks two things: the toggling sample is absent from the closing results, and the blanking it starts carries over into the new period.

The second pair is a toggle and an active blanking count. The bench toggles twice within one blanking window. It confirms that the discard span is measured from the second toggle.

A behavioural reference model is compared against every output on every clock. Directed scenarios with hand-computed sums back it up.

// File: rtl/phase_blank_accum.sv
module phase_blank_accum #(
  parameter int SMP_W = 12,
  parameter int PER_W = 14,
  parameter int BLK_W = 8,
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [SMP_W-1:0] smp,
  input  logic             phase,
  input  logic [BLK_W-1:0] blank_len,
  input  logic [PER_W-1:0] period_len,
  output logic             res_valid,
  output logic [ACC_W-1:0] sum0,
  output logic [ACC_W-1:0] sum1,
  output logic [PER_W-1:0] cnt0,
  output logic [PER_W-1:0] cnt1
);
  localparam int NPH = 2;

  logic             prev_ph;
  logic [BLK_W-1:0] blank_cnt;
  logic [PER_W-1:0] per_cnt;
  logic [ACC_W-1:0] acc    [NPH];
  logic [ACC_W-1:0] acc_nx [NPH];
  logic [PER_W-1:0] num    [NPH];
  logic [PER_W-1:0] num_nx [NPH];

  wire toggle = stb && (phase != prev_ph);
  wire drop   = toggle ? (blank_len != '0) : (blank_cnt != '0);
  wire take   = stb && !drop;
  wire last   = stb && ({1'b0, per_cnt} + 1'b1 >= {1'b0, period_len});

  always_comb begin
    for (int i = 0; i < NPH; i++) begin
      acc_nx[i] = acc[i];
      num_nx[i] = num[i];
      if (take && phase == 1'(i)) begin
        acc_nx[i] = acc[i] + ACC_W'(smp);
        num_nx[i] = num[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ph   <= phase;
      blank_cnt <= blank_len;
      per_cnt   <= '0;
      res_valid <= 1'b0;
      sum0 <= '0; sum1 <= '0; cnt0 <= '0; cnt1 <= '0;
      for (int i = 0; i < NPH; i++) begin
        acc[i] <= '0;
        num[i] <= '0;
      end
    end else begin
      res_valid <= last;
      if (stb) begin
        prev_ph <= phase;
        if (toggle)
          blank_cnt <= (blank_len == '0) ? '0 : blank_len - 1'b1;
        else if (blank_cnt != '0)
          blank_cnt <= blank_cnt - 1'b1;
        per_cnt <= last ? '0 : per_cnt + 1'b1;
        if (last) begin
          sum0 <= acc_nx[0]; sum1 <= acc_nx[1];
          cnt0 <= num_nx[0]; cnt1 <= num_nx[1];
        end
        for (int i = 0; i < NPH; i++) begin
          acc[i] <= last ? '0 : acc_nx[i];
          num[i] <= last ? '0 : num_nx[i];
        end
      end
    end
  end
endmodule

module phase_blank_accum_chk #(
  parameter int SMP_W = 12,
  parameter int PER_W = 14,
  parameter int ACC_W = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             stb,
  input logic             res_valid,
  input logic [ACC_W-1:0] sum0,
  input logic [ACC_W-1:0] sum1,
  input logic [PER_W-1:0] cnt0,
  input logic [PER_W-1:0] cnt1
);
  a_r1_reset_quiet: assert property (@(posedge clk) $past(rst) |-> !res_valid);

  a_r6_after_strobe: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(stb));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(sum0) && $stable(sum1) && $stable(cnt0) && $stable(cnt1)));

  a_r8_sum_bound: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (longint'(sum0) <= longint'(cnt0) * ((longint'(1) << SMP_W) - 1) &&
                   longint'(sum1) <= longint'(cnt1) * ((longint'(1) << SMP_W) - 1)));

  a_r4_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && cnt0 == '0) |-> sum0 == '0);
endmodule

bind phase_blank_accum phase_blank_accum_chk #(
  .SMP_W(SMP_W), .PER_W(PER_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .stb(stb), .res_valid(res_valid),
  .sum0(sum0), .sum1(sum1), .cnt0(cnt0), .cnt1(cnt1)
);

// File: tb/phase_blank_accum_test.sv
module phase_blank_accum_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stb = 1'b0;
  logic [11:0] smp = '0;
  logic        phase = 1'b0;
  logic [7:0]  blank_len = 8'd0;
  logic [13:0] period_len = 14'd10;
  logic        res_valid;
  logic [27:0] sum0, sum1;
  logic [13:0] cnt0, cnt1;

  int n_checks = 0;
  int n_err = 0;

  phase_blank_accum uut (
    .clk(clk), .rst(rst), .stb(stb), .smp(smp), .phase(phase),
    .blank_len(blank_len), .period_len(period_len),
    .res_valid(res_valid), .sum0(sum0), .sum1(sum1), .cnt0(cnt0), .cnt1(cnt1));

  always #2 clk = ~clk;

  // Behavioural reference
  int m_prev, m_blank, m_pos, m_acc[2], m_num[2];
  int e_valid = 0, e_sum[2] = '{0, 0}, e_cnt[2] = '{0, 0};
  bit armed = 0;

  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      m_prev = phase; m_blank = blank_len; m_pos = 0;
      m_acc = '{0, 0}; m_num = '{0, 0};
      e_valid = 0; e_sum = '{0, 0}; e_cnt = '{0, 0};
    end else begin
      e_valid = 0;
      if (stb) begin
        bit tog, keep, fin;
        int lim;
        tog = (phase != m_prev);
        m_prev = phase;
        if (tog) begin
          keep = (blank_len == 0);
          m_blank = (blank_len == 0) ? 0 : blank_len - 1;
        end else begin
          keep = (m_blank == 0);
          if (m_blank > 0) m_blank--;
        end
        if (keep) begin
          m_acc[phase] += smp;
          m_num[phase] += 1;
        end
        lim = (period_len == 0) ? 1 : period_len;
        m_pos++;
        fin = (m_pos >= lim);
        if (fin) begin
          e_valid = 1; e_sum = m_acc; e_cnt = m_num;
          m_acc = '{0, 0}; m_num = '{0, 0}; m_pos = 0;
        end
      end
    end
  end

  int q_s0[$], q_s1[$], q_c0[$], q_c1[$];

  always @(negedge clk) if (armed) begin
    n_checks++;
    if (res_valid !== 1'(e_valid) || sum0 !== 28'(e_sum[0]) || sum1 !== 28'(e_sum[1]) ||
        cnt0 !== 14'(e_cnt[0]) || cnt1 !== 14'(e_cnt[1])) begin
      n_err++;
      $display("FAIL R4/R6/R9 model: got v=%0b %0d %0d %0d %0d exp v=%0d %0d %0d %0d %0d",
               res_valid, sum0, sum1, cnt0, cnt1, e_valid, e_sum[0], e_sum[1], e_cnt[0], e_cnt[1]);
    end
    if (res_valid === 1'b1) begin
      q_s0.push_back(sum0); q_s1.push_back(sum1);
      q_c0.push_back(cnt0); q_c1.push_back(cnt1);
    end
  end

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset(input int blk, input int per, input bit ph);
    rst = 1; stb = 0; blank_len = 8'(blk); period_len = 14'(per); phase = ph;
    repeat (2) @(negedge clk);
    rst = 0;
    q_s0.delete(); q_s1.delete(); q_c0.delete(); q_c1.delete();
  endtask

  task automatic samp(input bit ph, input int v, input int gap);
    stb = 1; phase = ph; smp = 12'(v);
    @(negedge clk);
    stb = 0; smp = 12'hABC;
    repeat (gap) @(negedge clk);
  endtask

  task automatic expect_res(input string req, input int s0, input int s1, input int c0, input int c1);
    @(negedge clk);
    check({req, " count"}, q_s0.size(), 1);
    if (q_s0.size() > 0) begin
      check({req, " sum0"}, q_s0.pop_front(), s0);
      check({req, " sum1"}, q_s1.pop_front(), s1);
      check({req, " cnt0"}, q_c0.pop_front(), c0);
      check({req, " cnt1"}, q_c1.pop_front(), c1);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(3, 20, 0);
    check("R1 valid", res_valid, 0);
    check("R1 sum0", sum0, 0);
    check("R1 cnt1", cnt1, 0);
    // R1: three samples blanked after reset
    for (int i = 0; i < 20; i++) samp(0, 1, 0);
    expect_res("R1", 17, 0, 17, 0);
    // R7: continuous next period, no loss
    for (int i = 0; i < 20; i++) samp(0, 1, 0);
    expect_res("R7", 20, 0, 20, 0);

    // R2/R4: toggle mid-period, with gaps (R5)
    do_reset(4, 20, 0);
    for (int i = 0; i < 10; i++) samp(0, 2, 2);
    for (int i = 0; i < 10; i++) samp(1, 2, 1);
    expect_res("R2 R4 R5", 12, 12, 6, 6);

    // R3: toggle back while blanking
    do_reset(5, 30, 0);
    for (int i = 0; i < 10; i++) samp(0, 1, 0);
    for (int i = 0; i < 3; i++) samp(1, 1, 0);
    for (int i = 0; i < 17; i++) samp(0, 1, 0);
    expect_res("R3", 17, 0, 17, 0);

    // R2: blank_len 0, toggle every strobe
    do_reset(0, 10, 0);
    for (int i = 0; i < 10; i++) samp(1'(~i), 3, 0);
    expect_res("R2 zero blank", 15, 15, 5, 5);

    // R6/R7: toggle on last strobe of period, blanking carries over
    do_reset(2, 8, 0);
    for (int i = 0; i < 7; i++) samp(0, 5, 1);
    samp(1, 5, 0);
    check("R6 pulse", res_valid, 1);
    @(negedge clk);
    check("R6 one cycle", res_valid, 0);
    for (int i = 0; i < 8; i++) samp(1, 5, 1);
    check("R6 first result", q_s0.size(), 2);
    if (q_s0.size() == 2) begin
      check("R6 sum0", q_s0.pop_front(), 25);
      check("R6 cnt0", q_c0.pop_front(), 5);
      void'(q_s1.pop_front()); void'(q_c1.pop_front());
      check("R7 sum1", q_s1.pop_front(), 35);
      check("R7 cnt1", q_c1.pop_front(), 7);
    end
    // R9: outputs held
    repeat (5) @(negedge clk);
    check("R9 hold", cnt1, 7);

    // R6: period_len 0 behaves as 1
    do_reset(0, 0, 1);
    samp(1, 9, 0);
    expect_res("R6 zero period", 0, 9, 0, 1);

    // R8: full scale, long period
    do_reset(0, 10000, 0);
    for (int i = 0; i < 10000; i++) samp(0, 4095, 0);
    expect_res("R8", 40950000, 0, 10000, 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule